// File: doc/BRIEF.md
# Minterm-Gated Lookahead Adder and Logic Unit

This block is a 32-bit arithmetic and logic unit whose every function comes from one shared adder datapath. For each bit, the four two-input minterms of operands A and D are formed: A·D, A·¬D, ¬A·D and ¬A·¬D. A small decoder turns a 4-bit operation code into two sets of enables. One set chooses which minterms are ORed into the per-bit propagate term. The other chooses which of A·D, A·¬D and ¬A·D are ORed into the generate term. The decoder also supplies a carry-in.

Carries are resolved by full lookahead inside each 4-bit group, and each group's carry-out enters the next more significant group. Each result bit is its propagate term XOR its incoming carry. Logic functions enable no generate terms and a zero carry-in, so their result is the propagate term alone.

The result and the carry out of the most significant bit are captured in output registers, one clock after the inputs are presented. The result is gated by a sum-output enable. Bit 0 of every vector is the least significant.

Top module: `gp_lookahead_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `sum_o` = 0 and `cout_o` = 0.
- R2: Outputs appear one clock after the inputs are sampled. When `sum_en_i` is 0, `sum_o` is 0 in that next cycle, while `cout_o` still carries the carry-out of the selected operation.
- R3: Code 0 gives A+D and code 1 gives A+D+1. `cout_o` is bit 32 of the 33-bit sum.
- R4: Code 2 gives A−D and code 3 gives A−D−1, formed as A + ¬D + 1 and A + ¬D respectively. `cout_o` is the carry of that addition, so 1 means no borrow.
- R5: Code 4 gives D−A and code 5 gives D−A−1, formed as ¬A + D + 1 and ¬A + D. `cout_o` is the carry of that addition.
- R6: Code 6 gives A AND D, code 7 gives A OR D, and code 8 gives A XOR D.
- R7: Code 9 gives A AND ¬D, and code 10 gives ¬A AND D.
- R8: Code 11 passes A, code 12 passes D, and code 13 gives ¬A.
- R9: Codes 6 through 13 always give `cout_o` = 0.
- R10: Codes 14 and 15 are reserved. They give `sum_o` = 0 and `cout_o` = 0.
- R11: A carry propagates through every 4-bit group boundary. For example, FFFFFFFF + 1 gives 0 with `cout_o` = 1, and 0000000F + 1 gives 00000010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| op_i | input | 4 | Operation code (see R3 to R10) |
| a_i | input | 32 | Operand A |
| d_i | input | 32 | Operand D |
| sum_en_i | input | 1 | Sum-output enable; a 0 forces the registered result to zero |
| sum_o | output | 32 | Registered result |
| cout_o | output | 1 | Registered carry out of the most significant bit |

## Verification
The arithmetic codes are driven with operands chosen to stress the carry network. These include all-ones plus one, which sends a carry through every group boundary, a carry that crosses only the first boundary, equal operands in subtraction, and subtraction both with and without a borrow. Between them, these cases separate a broken in-group lookahead, a broken group-to-group link and a wrong carry-in. Fixed bit patterns with mixed nibbles go through each logic code, so that an enabled minterm that should be disabled, or the reverse, shows as a wrong bit. A long pseudo-random run over all sixteen codes follows. It uses a random sum-output enable and occasional resets, and compares each cycle with a behavioural model built on plain integer arithmetic.

// File: rtl/gpla_pkg.sv
package gpla_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADD1   = 4'd1,
    OP_SUB    = 4'd2,
    OP_SUBM1  = 4'd3,
    OP_RSUB   = 4'd4,
    OP_RSUBM1 = 4'd5,
    OP_AND    = 4'd6,
    OP_OR     = 4'd7,
    OP_XOR    = 4'd8,
    OP_ANDND  = 4'd9,
    OP_NANDD  = 4'd10,
    OP_PASSA  = 4'd11,
    OP_PASSD  = 4'd12,
    OP_NOTA   = 4'd13,
    OP_RSV14  = 4'd14,
    OP_RSV15  = 4'd15
  } alu_op_e;

  // propagate enable bit order: [0]=A&D [1]=A&~D [2]=~A&D [3]=~A&~D
  // generate enable bit order:  [0]=A&D [1]=A&~D [2]=~A&D
  typedef struct packed {
    logic [3:0] p_en;
    logic [2:0] g_en;
    logic       cin;
  } term_sel_t;

endpackage

// File: rtl/gpla_decode.sv
module gpla_decode
  import gpla_pkg::*;
(
  input  logic [3:0] op_i,
  output term_sel_t  sel_o
);

  localparam logic [3:0] P_XOR  = 4'b0110;
  localparam logic [3:0] P_XNOR = 4'b1001;

  always_comb begin
    sel_o = '0;
    case (alu_op_e'(op_i))
      OP_ADD:    begin sel_o.p_en = P_XOR;  sel_o.g_en = 3'b001; sel_o.cin = 1'b0; end
      OP_ADD1:   begin sel_o.p_en = P_XOR;  sel_o.g_en = 3'b001; sel_o.cin = 1'b1; end
      OP_SUB:    begin sel_o.p_en = P_XNOR; sel_o.g_en = 3'b010; sel_o.cin = 1'b1; end
      OP_SUBM1:  begin sel_o.p_en = P_XNOR; sel_o.g_en = 3'b010; sel_o.cin = 1'b0; end
      OP_RSUB:   begin sel_o.p_en = P_XNOR; sel_o.g_en = 3'b100; sel_o.cin = 1'b1; end
      OP_RSUBM1: begin sel_o.p_en = P_XNOR; sel_o.g_en = 3'b100; sel_o.cin = 1'b0; end
      OP_AND:    sel_o.p_en = 4'b0001;
      OP_OR:     sel_o.p_en = 4'b0111;
      OP_XOR:    sel_o.p_en = P_XOR;
      OP_ANDND:  sel_o.p_en = 4'b0010;
      OP_NANDD:  sel_o.p_en = 4'b0100;
      OP_PASSA:  sel_o.p_en = 4'b0011;
      OP_PASSD:  sel_o.p_en = 4'b0101;
      OP_NOTA:   sel_o.p_en = 4'b1100;
      default:   sel_o = '0;
    endcase
  end

endmodule

// File: rtl/gpla_bit_terms.sv
module gpla_bit_terms #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [3:0]       p_en_i,
  input  logic [2:0]       g_en_i,
  output logic [WIDTH-1:0] p_o,
  output logic [WIDTH-1:0] g_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic m_ad, m_and, m_nad, m_nand;
    assign m_ad   =  a_i[b] &  d_i[b];
    assign m_and  =  a_i[b] & ~d_i[b];
    assign m_nad  = ~a_i[b] &  d_i[b];
    assign m_nand = ~a_i[b] & ~d_i[b];
    assign p_o[b] = (p_en_i[0] & m_ad) | (p_en_i[1] & m_and) |
                    (p_en_i[2] & m_nad) | (p_en_i[3] & m_nand);
    assign g_o[b] = (g_en_i[0] & m_ad) | (g_en_i[1] & m_and) |
                    (g_en_i[2] & m_nad);
  end

endmodule

// File: rtl/gpla_carry_group.sv
module gpla_carry_group #(
  parameter int GROUP = 4
) (
  input  logic [GROUP-1:0] g_i,
  input  logic [GROUP-1:0] p_i,
  input  logic             cin_i,
  output logic [GROUP-1:0] c_o,
  output logic             cout_o
);

  logic [GROUP:0] cc;

  // Flat lookahead: carry into position j from the carry-in and every
  // generate below j, each qualified by the propagates between them.
  always_comb begin
    logic acc;
    logic term;
    for (int j = 0; j <= GROUP; j++) begin
      acc = cin_i;
      for (int k = 0; k < j; k++) acc = acc & p_i[k];
      for (int k = 0; k < j; k++) begin
        term = g_i[k];
        for (int m = k + 1; m < j; m++) term = term & p_i[m];
        acc = acc | term;
      end
      cc[j] = acc;
    end
  end

  assign c_o    = cc[GROUP-1:0];
  assign cout_o = cc[GROUP];

endmodule

// File: rtl/gp_lookahead_alu.sv
module gp_lookahead_alu
  import gpla_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             sum_en_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int NGROUPS = WIDTH / GROUP;

  term_sel_t          sel;
  logic [WIDTH-1:0]   prop;
  logic [WIDTH-1:0]   gen;
  logic [WIDTH-1:0]   carry;
  logic [NGROUPS:0]   gcarry;
  logic [WIDTH-1:0]   sum_c;

  gpla_decode u_dec (
    .op_i  (op_i),
    .sel_o (sel)
  );

  gpla_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .a_i    (a_i),
    .d_i    (d_i),
    .p_en_i (sel.p_en),
    .g_en_i (sel.g_en),
    .p_o    (prop),
    .g_o    (gen)
  );

  assign gcarry[0] = sel.cin;

  for (genvar gi = 0; gi < NGROUPS; gi++) begin : g_grp
    gpla_carry_group #(.GROUP(GROUP)) u_cg (
      .g_i    (gen[gi*GROUP +: GROUP]),
      .p_i    (prop[gi*GROUP +: GROUP]),
      .cin_i  (gcarry[gi]),
      .c_o    (carry[gi*GROUP +: GROUP]),
      .cout_o (gcarry[gi+1])
    );
  end

  assign sum_c = prop ^ carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_en_i ? sum_c : '0;
      cout_o <= gcarry[NGROUPS];
    end
  end

endmodule

// File: rtl/gp_lookahead_alu_sva.sv
module gp_lookahead_alu_sva #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] d_i,
  input logic             sum_en_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);

  assert_sum_gated_R2: assert property (@(posedge clk) disable iff (rst)
    !sum_en_i |=> (sum_o == '0));

  assert_add_result_R3: assert property (@(posedge clk) disable iff (rst)
    (sum_en_i && op_i == 4'd0) |=>
      ({cout_o, sum_o} == $past({1'b0, a_i} + {1'b0, d_i})));

  assert_sub_result_R4: assert property (@(posedge clk) disable iff (rst)
    (sum_en_i && op_i == 4'd2) |=> (sum_o == $past(a_i - d_i)));

  assert_xor_result_R6: assert property (@(posedge clk) disable iff (rst)
    (sum_en_i && op_i == 4'd8) |=> (sum_o == $past(a_i ^ d_i)));

  assert_logic_no_carry_R9: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 4'd6) |=> !cout_o);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 4'd14) |=> (sum_o == '0));

endmodule

bind gp_lookahead_alu gp_lookahead_alu_sva #(.WIDTH(WIDTH)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .a_i      (a_i),
  .d_i      (d_i),
  .sum_en_i (sum_en_i),
  .sum_o    (sum_o),
  .cout_o   (cout_o)
);

// File: tb/gp_lookahead_alu_tb.sv
`timescale 1ns/1ps
module gp_lookahead_alu_tb;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_i = '0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] d_i = '0;
  logic         sum_en_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         cout_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [31:0] rs = 32'h1234_5679;

  always #4 clk = ~clk;

  gp_lookahead_alu #(.WIDTH(W), .GROUP(4)) u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .d_i(d_i),
    .sum_en_i(sum_en_i), .sum_o(sum_o), .cout_o(cout_o)
  );

  function automatic logic [W:0] model(input logic [3:0] op,
                                       input logic [W-1:0] a,
                                       input logic [W-1:0] d);
    logic [W:0] r;
    case (op)
      4'd0:  r = {1'b0, a} + {1'b0, d};
      4'd1:  r = {1'b0, a} + {1'b0, d} + 1;
      4'd2:  r = {1'b0, a} + {1'b0, ~d} + 1;
      4'd3:  r = {1'b0, a} + {1'b0, ~d};
      4'd4:  r = {1'b0, ~a} + {1'b0, d} + 1;
      4'd5:  r = {1'b0, ~a} + {1'b0, d};
      4'd6:  r = {1'b0, a & d};
      4'd7:  r = {1'b0, a | d};
      4'd8:  r = {1'b0, a ^ d};
      4'd9:  r = {1'b0, a & ~d};
      4'd10: r = {1'b0, ~a & d};
      4'd11: r = {1'b0, a};
      4'd12: r = {1'b0, d};
      4'd13: r = {1'b0, ~a};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic en,
                                   input logic r);
    if (r) return "R1";
    if (!en) return "R2";
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7, 4'd8: return "R6";
      4'd9, 4'd10: return "R7";
      4'd11, 4'd12, 4'd13: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input logic [3:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] d, input logic en,
                      input logic r, input string tag);
    logic [W:0] exp;
    @(negedge clk);
    op_i = op; a_i = a; d_i = d; sum_en_i = en; rst = r;
    @(posedge clk);
    #1;
    exp = r ? '0 : model(op, a, d);
    if (!r && !en) exp[W-1:0] = '0;
    total++;
    if ({cout_o, sum_o} !== exp) begin
      bad++;
      $display("FAIL %s op=%0d: actual cout=%b sum=%h expected cout=%b sum=%h",
               tag, op, cout_o, sum_o, exp[W], exp[W-1:0]);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    // R1: reset with active inputs
    step(4'd0, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b1, "R1");
    step(4'd7, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, 1'b1, "R1");
    // R3 and R11: carries across group boundaries
    step(4'd0, 32'd1, 32'd2, 1'b1, 1'b0, "R3");
    step(4'd1, 32'd1, 32'd2, 1'b1, 1'b0, "R3");
    step(4'd0, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b0, "R11");
    step(4'd0, 32'h0000_000F, 32'h1, 1'b1, 1'b0, "R11");
    step(4'd1, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, "R11");
    step(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R3");
    // R4 and R5: subtraction with and without borrow
    step(4'd2, 32'd5, 32'd7, 1'b1, 1'b0, "R4");
    step(4'd2, 32'd9, 32'd9, 1'b1, 1'b0, "R4");
    step(4'd3, 32'd9, 32'd9, 1'b1, 1'b0, "R4");
    step(4'd4, 32'd5, 32'd7, 1'b1, 1'b0, "R5");
    step(4'd5, 32'd7, 32'd5, 1'b1, 1'b0, "R5");
    step(4'd4, 32'h0, 32'h0, 1'b1, 1'b0, "R5");
    // R6..R10: logic, pass and reserved codes with mixed nibbles
    for (int k = 6; k < 16; k++)
      step(4'(k), 32'hF0F0_33CC, 32'hFF00_5A5A, 1'b1, 1'b0,
           tag_of(4'(k), 1'b1, 1'b0));
    // R9: logic ops with operands that would carry if added
    for (int k = 6; k < 14; k++)
      step(4'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R9");
    // R2: enable low keeps sum zero, carry still reported
    step(4'd0, 32'hFFFF_FFFF, 32'h2, 1'b0, 1'b0, "R2");
    step(4'd7, 32'h1234_5678, 32'h0, 1'b0, 1'b0, "R2");
    // pseudo-random sweep
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra, rd, rc;
      rs = nxt(rs); ra = rs;
      rs = nxt(rs); rd = rs;
      rs = nxt(rs); rc = rs;
      if (rc[7:5] == 3'd0) rd = ~ra + {31'd0, rc[8]};
      step(rc[3:0], ra, rd, rc[4] | rc[9], rc[15:10] == 6'd0,
           tag_of(rc[3:0], rc[4] | rc[9], rc[15:10] == 6'd0));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule